// File: doc/BRIEF.md
# Real-Time Counter with Alarm Compare and Periodic Tick Timer

This block keeps time from a slow tick enable, nominally 32.768 kHz, so whole seconds equal the count shifted right by 15. It holds a free-running real-time count that is split into a low half and a high half. Each half can be held on its own, and a clear control forces the count to zero and keeps it there.

An alarm compare value raises a status flag when the count steps onto it. A periodic down-counter reloads a programmed value N and flags once every N+1 ticks, so a 100 Hz rate uses N = 32768/100 − 1. A full wrap of the count from all ones to zero also raises a flag. The three flags are sticky, are cleared by writing 1 to them, and are masked onto a single registered interrupt line.

Software reads and writes eight word registers over a simple synchronous port. The count words are live values, so software reads them twice to catch a carry between the two reads.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the count, control word, alarm value, reload value, status and mask are zero, and `irq` is low. Read data appears on `rdata` one clock after `addr` is presented.
- R2: Each cycle with `tick` high advances the count by one. Address 1 returns the low LO_W bits and address 2 returns the upper RTC_W−LO_W bits, both zero-extended.
- R3: The count words are live. After the low word reads all ones, one tick makes the low word zero and the high word one larger, and this carry is seen between two reads.
- R4: Control bit 1 holds the low half, and no carry reaches the high half while it is held. Control bit 0 holds the high half while the low half keeps counting and wrapping.
- R5: Control bit 2 forces the count to zero and keeps it there whatever the ticks do. When the bit is cleared, counting resumes from zero.
- R6: A tick that moves the full count from all ones to zero sets status bit 31.
- R7: A tick that steps the count onto the alarm value sets status bit 30. The alarm's low LO_W bits are written at address 3 and its upper bits at address 4.
- R8: Control bit 3 enables the periodic timer and control bit 4 holds it. While it is disabled it loads the reload value from address 5. While it is enabled and not held, status bit 29 sets on every (N+1)-th tick. Holding it stops the flag.
- R9: Status is read at address 6. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R10: Address 7 holds an enable mask in bits 31..29, aligned with the status bits. `irq` is the registered OR of status AND mask, so it follows one clock after either changes.
- R11: The control word reads back at address 0. Writing zero to it leaves every hold, clear and enable bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at the time base rate |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the previous `addr` |
| irq | output | 1 | Registered masked interrupt |

## Verification
A low half that steps wrongly shows up on the next read of address 1. A carry that is lost or doubled shows up one tick later, at the first read of address 2 after the low word wraps. A wrong alarm compare or a wrong periodic down-count sets a status bit a tick early, a tick late or not at all, and this is seen at the read of address 6 right after the tick in question. A wrong sticky or mask state reaches `irq` one clock after the status changes.

// File: rtl/rtc_tmr_pkg.sv
package rtc_tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALM_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALM_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd6;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd7;

  // control bit positions
  localparam int C_HOLD_HI  = 0;
  localparam int C_HOLD_LO  = 1;
  localparam int C_CLR      = 2;
  localparam int C_PER_EN   = 3;
  localparam int C_PER_HOLD = 4;

  // event index inside the 3-bit status vector; bit i maps to word bit DATA_W-3+i
  localparam int EV_PER  = 0;
  localparam int EV_ALM  = 1;
  localparam int EV_ROLL = 2;
  localparam int EV_N    = 3;
endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int RTC_W = 40,
  parameter int LO_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             hold_hi,
  input  logic             hold_lo,
  input  logic             clr,
  output logic [RTC_W-1:0] cnt,
  output logic [RTC_W-1:0] nxt,
  output logic             step,
  output logic             wrap
);
  localparam int HI_W = RTC_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            hi_step;

  assign step    = tick & ~clr & ~hold_lo;
  assign hi_step = step & (&lo_q) & ~hold_hi;
  assign wrap    = hi_step & (&hi_q);
  assign cnt     = {hi_q, lo_q};
  assign nxt     = {hi_step ? hi_q + 1'b1 : hi_q, lo_q + 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (step)    lo_q <= lo_q + 1'b1;
      if (hi_step) hi_q <= hi_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             hold,
  input  logic [PER_W-1:0] reload,
  output logic             expire
);
  logic [PER_W-1:0] left_q;
  logic             run;

  assign run    = en & tick & ~hold;
  assign expire = run & (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst)          left_q <= '0;
    else if (!en)     left_q <= reload;
    else if (expire)  left_q <= reload;
    else if (run)     left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_tmr_pkg::*;
#(
  parameter int RTC_W  = 40,
  parameter int LO_W   = 32,
  parameter int PER_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int HI_W  = RTC_W - LO_W;
  localparam int ST_LO = DATA_W - EV_N;

  logic [CTRL_W-1:0] ctrl_q;
  logic [RTC_W-1:0]  alm_q;
  logic [PER_W-1:0]  reload_q;
  logic [EV_N-1:0]   st_q, st_d, mask_q, ev;
  logic [RTC_W-1:0]  rtc_q, rtc_nxt;
  logic              rtc_step, rtc_wrap, per_exp;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              irq_q;

  rtc_count #(.RTC_W(RTC_W), .LO_W(LO_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .hold_hi(ctrl_q[C_HOLD_HI]), .hold_lo(ctrl_q[C_HOLD_LO]), .clr(ctrl_q[C_CLR]),
    .cnt(rtc_q), .nxt(rtc_nxt), .step(rtc_step), .wrap(rtc_wrap)
  );

  rtc_periodic #(.PER_W(PER_W)) u_per (
    .clk(clk), .rst(rst), .tick(tick),
    .en(ctrl_q[C_PER_EN]), .hold(ctrl_q[C_PER_HOLD]),
    .reload(reload_q), .expire(per_exp)
  );

  always_comb begin
    ev          = '0;
    ev[EV_PER]  = per_exp;
    ev[EV_ALM]  = rtc_step && (rtc_nxt == alm_q);
    ev[EV_ROLL] = rtc_wrap;
  end

  for (genvar i = 0; i < EV_N; i++) begin : g_st
    assign st_d[i] = ev[i] | (st_q[i] & ~(we && addr == A_STAT && wdata[ST_LO+i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      alm_q    <= '0;
      reload_q <= '0;
      mask_q   <= '0;
      st_q     <= '0;
    end else begin
      st_q <= st_d;
      if (we) begin
        unique case (addr)
          A_CTRL:   ctrl_q <= wdata[CTRL_W-1:0];
          A_ALM_LO: alm_q[LO_W-1:0] <= wdata[LO_W-1:0];
          A_ALM_HI: alm_q[RTC_W-1:LO_W] <= wdata[HI_W-1:0];
          A_RELOAD: reload_q <= wdata[PER_W-1:0];
          A_MASK:   mask_q <= wdata[DATA_W-1:ST_LO];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
      A_CNT_LO: rd_mux[LO_W-1:0]   = rtc_q[LO_W-1:0];
      A_CNT_HI: rd_mux[HI_W-1:0]   = rtc_q[RTC_W-1:LO_W];
      A_ALM_LO: rd_mux[LO_W-1:0]   = alm_q[LO_W-1:0];
      A_ALM_HI: rd_mux[HI_W-1:0]   = alm_q[RTC_W-1:LO_W];
      A_RELOAD: rd_mux[PER_W-1:0]  = reload_q;
      A_STAT:   rd_mux[DATA_W-1:ST_LO] = st_q;
      A_MASK:   rd_mux[DATA_W-1:ST_LO] = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= |(st_q & mask_q);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk
  import rtc_tmr_pkg::*;
#(
  parameter int RTC_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CTRL_W-1:0] ctrl,
  input logic [RTC_W-1:0]  rtc,
  input logic [EV_N-1:0]   st,
  input logic [EV_N-1:0]   mask,
  input logic              irq
);
  // R1
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (rtc == '0 && st == '0 && !irq));

  // R2
  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctrl[C_CLR] && !ctrl[C_HOLD_LO] && !ctrl[C_HOLD_HI])
      |=> rtc == RTC_W'($past(rtc) + 1'b1));

  // R4
  a_r4_hold_lo: assert property (@(posedge clk) disable iff (rst)
    ((ctrl[C_HOLD_LO] || !tick) && !ctrl[C_CLR]) |=> $stable(rtc));

  // R5
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    ctrl[C_CLR] |=> rtc == '0);

  // R6
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(st[EV_ROLL]) |-> rtc == '0);

  // R10
  a_r10_irq_on: assert property (@(posedge clk) disable iff (rst)
    (|(st & mask)) |=> irq);
  a_r10_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(|(st & mask)) |=> !irq);
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.RTC_W(RTC_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl_q), .rtc(rtc_q),
  .st(st_q), .mask(mask_q), .irq(irq)
);

// File: tb/sim_rtc_alarm_timer.sv
module sim_rtc_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int RTC_W = 12;
  localparam int LO_W  = 8;
  localparam int PER_W = 8;

  localparam logic [31:0] ST_ROLL = 32'h8000_0000;
  localparam logic [31:0] ST_ALM  = 32'h4000_0000;
  localparam logic [31:0] ST_PER  = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [31:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_alarm_timer #(.RTC_W(RTC_W), .LO_W(LO_W), .PER_W(PER_W), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pops expected reads when their data is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.exp = exp; it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'h0, "R1 count lo");
    rd(3'd6, 32'h0, "R1 status");
    rd(3'd7, 32'h0, "R1 mask");
    chk_irq(1'b0, "R1 irq");
    // R2 counting
    ticks(5);
    rd(3'd1, 32'd5, "R2 lo after 5 ticks");
    rd(3'd2, 32'd0, "R2 hi after 5 ticks");
    // R3 carry between reads
    ticks(250);
    rd(3'd1, 32'd255, "R3 lo all ones");
    ticks(1);
    rd(3'd2, 32'd1, "R3 hi carried");
    rd(3'd1, 32'd0, "R3 lo wrapped");
    // R4 holds
    wr(3'd0, 32'h2);
    ticks(3);
    rd(3'd1, 32'd0, "R4 lo held");
    rd(3'd2, 32'd1, "R4 hi no carry");
    wr(3'd0, 32'h1);
    ticks(256);
    rd(3'd1, 32'd0, "R4 lo wrapped under hi hold");
    rd(3'd2, 32'd1, "R4 hi held");
    // R5 clear
    wr(3'd0, 32'h4);
    ticks(3);
    rd(3'd1, 32'd0, "R5 lo cleared");
    rd(3'd2, 32'd0, "R5 hi cleared");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R11 ctrl zero");
    ticks(3);
    rd(3'd1, 32'd3, "R5 resume from zero");
    // R7 alarm at 10
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd0);
    ticks(6);
    rd(3'd6, 32'h0, "R7 no alarm before match");
    ticks(1);
    rd(3'd6, ST_ALM, "R7 alarm on match");
    wr(3'd6, 32'h0);
    rd(3'd6, ST_ALM, "R9 zero write keeps");
    wr(3'd6, ST_ALM);
    rd(3'd6, 32'h0, "R9 one write clears");
    // R6 full wrap
    wr(3'd0, 32'h4);
    wr(3'd0, 32'h0);
    ticks(4095);
    rd(3'd6, ST_ALM, "R7 alarm passed on the way");
    wr(3'd6, 32'hE000_0000);
    rd(3'd1, 32'hFF, "R6 lo at all ones");
    ticks(1);
    rd(3'd6, ST_ROLL, "R6 rollover flag");
    rd(3'd2, 32'd0, "R6 hi wrapped");
    // R10 mask
    wr(3'd7, ST_ROLL);
    chk_irq(1'b1, "R10 irq enabled");
    wr(3'd7, ST_ALM);
    chk_irq(1'b0, "R10 irq masked");
    wr(3'd6, ST_ROLL);
    // R8 periodic
    wr(3'd4, 32'hF);
    wr(3'd5, 32'd3);
    wr(3'd0, 32'h8);
    ticks(3);
    rd(3'd6, 32'h0, "R8 not yet");
    ticks(1);
    rd(3'd6, ST_PER, "R8 expire after N+1");
    wr(3'd6, ST_PER);
    ticks(3);
    rd(3'd6, 32'h0, "R8 second period pending");
    ticks(1);
    rd(3'd6, ST_PER, "R8 second expire");
    wr(3'd6, ST_PER);
    wr(3'd0, 32'h18);
    ticks(8);
    rd(3'd6, 32'h0, "R8 held no expire");
    rd(3'd0, 32'h18, "R11 ctrl readback");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R11 ctrl cleared");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule